// File: doc/BRIEF.md
# Pipelined Reciprocal-Multiply Remainder Unit

This block returns the remainder and the quotient of an unsigned input word divided by a small fixed divisor, 3 or 9. It has no divider. It first estimates the quotient by multiplying the input by a truncated fixed-point reciprocal of the divisor, keeping the upper half of the product. It then rebuilds quotient times divisor with one shift and one add, and subtracts that from the input to get a preliminary remainder. A final correction step brings the preliminary remainder back into range and adjusts the quotient to match.

The datapath has four register stages. Every operand a stage uses comes from the registers of the stage just before it, and the original input travels alongside the quotient in copy registers. The unit takes a new sample on every clock and has no back-pressure. A valid flag goes with each sample, so the output valid is the input valid delayed by exactly four cycles. The parameter `DIVISOR` picks the modulo-3 or the modulo-9 build, and that choice also sets the width of the remainder port.

Top module: `modred_unit`

## Requirements
- R1: For every input value in the full 16-bit range, out_rem equals in_data modulo DIVISOR.
- R2: For every input value, out_quot equals in_data divided by DIVISOR, rounded down.
- R3: out_valid equals in_valid as it was sampled four rising edges earlier. A sample taken at edge k appears on the outputs just after edge k+3.
- R4: A new sample is accepted on every clock. Back-to-back samples with different values each produce their own correct result, with no mixing between stages.
- R5: A synchronous active-high reset clears every valid flag. out_valid is 0 after any edge at which rst is 1, and samples already in flight are dropped.
- R6: Exact multiples and range extremes come out right, even though the reciprocal estimate can be one too small. Examples: input 3 gives remainder 0 and quotient 1; input 0 gives 0 and 0; input 65535 gives remainder 0 and quotient 21845 in the modulo-3 build.
- R7: With DIVISOR = 9 the unit uses a 2^16/9 reciprocal (0x1C71) and a shift-by-3-plus-add rebuild, and gives correct remainder and quotient for all inputs.
- R8: out_rem is 2 bits wide when DIVISOR = 3 and 4 bits wide when DIVISOR = 9. A valid remainder is always less than DIVISOR.
- R9: Cycles with in_valid low produce cycles with out_valid low four cycles later, whatever in_data held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Marks in_data as a sample to process |
| in_data | input | DATA_W (16) | Unsigned dividend |
| out_valid | output | 1 | Marks out_rem and out_quot as a result |
| out_rem | output | $clog2(DIVISOR) | Remainder (2 bits for 3, 4 bits for 9) |
| out_quot | output | DATA_W (16) | Quotient, rounded down |

## Verification
A short table of hand-worked corner values is streamed first: zero, exact multiples, values next to multiples, and the top of the range. Each carries expected results for both divisors, and this shows whether the short-by-one correction fires in the right places. Then every one of the 65536 inputs is streamed with a new value each cycle, into a modulo-3 and a modulo-9 instance side by side. A reciprocal constant that is off, or a stage that takes an operand from the wrong sample, gives a miscompare that holding the input constant would hide. Gapped valid patterns, and a reset asserted while samples are in flight, separate correct valid delay and flushing from results that only look right in steady streaming.

// File: rtl/modred_pkg.sv
package modred_pkg;

    // Truncated fixed-point reciprocal: floor(2^dw / d)
    function automatic longint recip_const(input int dw, input int d);
        return (64'sd1 <<< dw) / d;
    endfunction

    // Divisor is 2^s + 1, so times-divisor is (q << s) + q
    function automatic int rebuild_shift(input int d);
        return $clog2(d - 1);
    endfunction

endpackage

// File: rtl/modred_recip_stage.sv
module modred_recip_stage #(
    parameter int DATA_W  = 16,
    parameter int DIVISOR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_x,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_x,
    output logic [DATA_W-1:0] out_q
);
    localparam logic [DATA_W-1:0] RECIP =
        DATA_W'(modred_pkg::recip_const(DATA_W, DIVISOR));
    localparam logic [DATA_W-1:0] DIV_W = DATA_W'(DIVISOR);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] q;
    } st_t;

    st_t st_d, st_q;
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        prod     = {{DATA_W{1'b0}}, in_x} * {{DATA_W{1'b0}}, RECIP};
        st_d.vld = in_vld;
        st_d.x   = in_x;
        st_d.q   = DATA_W'(prod >> DATA_W);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) st_q.vld <= 1'b0;
    end

    assign out_vld = st_q.vld;
    assign out_x   = st_q.x;
    assign out_q   = st_q.q;

    // R3
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R9
    bubble_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R6
    est_not_high_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_q <= $past(in_x) / DIV_W);
    // R6
    est_short_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ({1'b0, out_q} + (DATA_W+1)'(1)) >= {1'b0, $past(in_x) / DIV_W});
endmodule

// File: rtl/modred_rebuild_stage.sv
module modred_rebuild_stage #(
    parameter int DATA_W  = 16,
    parameter int DIVISOR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_pre,
    output logic [DATA_W-1:0] out_q
);
    localparam int SH = modred_pkg::rebuild_shift(DIVISOR);
    localparam int PW = DATA_W + SH + 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] q;
        logic [PW-1:0]     qd;
    } mul_st_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] pre;
        logic [DATA_W-1:0] q;
    } sub_st_t;

    mul_st_t mul_d, mul_q;
    sub_st_t sub_d, sub_q;

    always_comb begin
        // stage 2: quotient times divisor by shift plus add
        mul_d.vld = in_vld;
        mul_d.x   = in_x;
        mul_d.q   = in_q;
        mul_d.qd  = {1'b0, in_q, {SH{1'b0}}} + PW'(in_q);
        // stage 3: preliminary remainder, operands all from stage 2 registers
        sub_d.vld = mul_q.vld;
        sub_d.pre = mul_q.x - mul_q.qd[DATA_W-1:0];
        sub_d.q   = mul_q.q;
    end

    always_ff @(posedge clk) begin
        mul_q <= mul_d;
        sub_q <= sub_d;
        if (rst) begin
            mul_q.vld <= 1'b0;
            sub_q.vld <= 1'b0;
        end
    end

    assign out_vld = sub_q.vld;
    assign out_pre = sub_q.pre;
    assign out_q   = sub_q.q;

    // R2
    rebuild_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
        mul_q.vld |-> mul_q.qd <= PW'(mul_q.x));
    // R3
    sub_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mul_q.vld |=> out_vld);
endmodule

// File: rtl/modred_fix_stage.sv
module modred_fix_stage #(
    parameter int DATA_W  = 16,
    parameter int DIVISOR = 3,
    parameter int REM_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_pre,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_vld,
    output logic [REM_W-1:0]  out_rem,
    output logic [DATA_W-1:0] out_quot
);
    localparam logic [DATA_W-1:0] D1 = DATA_W'(DIVISOR);
    localparam logic [DATA_W-1:0] D2 = DATA_W'(2 * DIVISOR);
    localparam logic [DATA_W-1:0] D3 = DATA_W'(3 * DIVISOR);

    typedef struct packed {
        logic              vld;
        logic [REM_W-1:0]  rem;
        logic [DATA_W-1:0] quot;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.vld = in_vld;
        if (in_pre >= D2) begin
            st_d.rem  = REM_W'(in_pre - D2);
            st_d.quot = in_q + DATA_W'(2);
        end else if (in_pre >= D1) begin
            st_d.rem  = REM_W'(in_pre - D1);
            st_d.quot = in_q + DATA_W'(1);
        end else begin
            st_d.rem  = REM_W'(in_pre);
            st_d.quot = in_q;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) st_q.vld <= 1'b0;
    end

    assign out_vld  = st_q.vld;
    assign out_rem  = st_q.rem;
    assign out_quot = st_q.quot;

    // R6
    pre_headroom_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> in_pre < D3);
    // R8
    rem_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> {{(DATA_W-REM_W){1'b0}}, out_rem} < D1);
endmodule

// File: rtl/modred_unit.sv
module modred_unit #(
    parameter int DATA_W  = 16,
    parameter int DIVISOR = 3,
    localparam int REM_W  = $clog2(DIVISOR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [REM_W-1:0]  out_rem,
    output logic [DATA_W-1:0] out_quot
);
    logic              s1_vld, s3_vld;
    logic [DATA_W-1:0] s1_x, s1_q, s3_pre, s3_q;

    modred_recip_stage #(.DATA_W(DATA_W), .DIVISOR(DIVISOR)) recip_i (
        .clk(clk), .rst(rst), .in_vld(in_valid), .in_x(in_data),
        .out_vld(s1_vld), .out_x(s1_x), .out_q(s1_q)
    );

    modred_rebuild_stage #(.DATA_W(DATA_W), .DIVISOR(DIVISOR)) rebuild_i (
        .clk(clk), .rst(rst), .in_vld(s1_vld), .in_x(s1_x), .in_q(s1_q),
        .out_vld(s3_vld), .out_pre(s3_pre), .out_q(s3_q)
    );

    modred_fix_stage #(.DATA_W(DATA_W), .DIVISOR(DIVISOR), .REM_W(REM_W)) fix_i (
        .clk(clk), .rst(rst), .in_vld(s3_vld), .in_pre(s3_pre), .in_q(s3_q),
        .out_vld(out_valid), .out_rem(out_rem), .out_quot(out_quot)
    );

    // R2
    quot_rem_fit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'(out_quot) * DIVISOR + longint'(out_rem))
                      < (64'sd1 <<< DATA_W));
endmodule

// File: tb/modred_unit_tb_top.sv
module modred_unit_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        v3, v9;
    logic [1:0]  r3;
    logic [3:0]  r9;
    logic [15:0] q3, q9;

    // expected results travelling with the current input
    logic [1:0]  c_r3 = '0;
    logic [3:0]  c_r9 = '0;
    logic [15:0] c_q3 = '0, c_q9 = '0;
    bit          c_tbl = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    modred_unit #(.DATA_W(16), .DIVISOR(3)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v3), .out_rem(r3), .out_quot(q3)
    );
    modred_unit #(.DATA_W(16), .DIVISOR(9)) dut9_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v9), .out_rem(r9), .out_quot(q9)
    );

    // corner table: input, mod3 rem, mod3 quot, mod9 rem, mod9 quot (R6)
    localparam int NT = 12;
    localparam int TX  [NT] = '{0, 3, 8, 9, 17, 1000, 65528, 65529, 65532, 65533, 65534, 65535};
    localparam int TR3 [NT] = '{0, 0, 2, 0, 2, 1, 2, 0, 0, 1, 2, 0};
    localparam int TQ3 [NT] = '{0, 1, 2, 3, 5, 333, 21842, 21843, 21844, 21844, 21844, 21845};
    localparam int TR9 [NT] = '{0, 3, 8, 0, 8, 1, 8, 0, 3, 4, 5, 6};
    localparam int TQ9 [NT] = '{0, 0, 0, 1, 1, 111, 7280, 7281, 7281, 7281, 7281, 7281};

    // independent four-deep delay model of valid and expectations (R3)
    logic        m_v  [4];
    logic [1:0]  m_r3 [4];
    logic [3:0]  m_r9 [4];
    logic [15:0] m_q3 [4];
    logic [15:0] m_q9 [4];
    bit          m_tb [4];

    always @(posedge clk) begin
        m_v[0] <= in_valid; m_r3[0] <= c_r3; m_r9[0] <= c_r9;
        m_q3[0] <= c_q3; m_q9[0] <= c_q9; m_tb[0] <= c_tbl;
        for (int i = 1; i < 4; i++) begin
            m_v[i] <= m_v[i-1]; m_r3[i] <= m_r3[i-1]; m_r9[i] <= m_r9[i-1];
            m_q3[i] <= m_q3[i-1]; m_q9[i] <= m_q9[i-1]; m_tb[i] <= m_tb[i-1];
        end
        if (rst) for (int i = 0; i < 4; i++) m_v[i] <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(v3 == m_v[3], "R3 valid mod3", longint'(v3), longint'(m_v[3]));
            check(v9 == m_v[3], "R3 valid mod9", longint'(v9), longint'(m_v[3]));
            if (m_v[3] && v3 && v9) begin
                check(r3 == m_r3[3], m_tb[3] ? "R6 rem mod3" : "R1 rem mod3",
                      longint'(r3), longint'(m_r3[3]));
                check(q3 == m_q3[3], m_tb[3] ? "R6 quot mod3" : "R2 quot mod3",
                      longint'(q3), longint'(m_q3[3]));
                check(r9 == m_r9[3], "R7 rem mod9", longint'(r9), longint'(m_r9[3]));
                check(q9 == m_q9[3], "R7 quot mod9", longint'(q9), longint'(m_q9[3]));
            end
        end
    end

    task automatic drive(input bit v, input int x, input bit tbl,
                         input int e3, input int eq3, input int e9, input int eq9);
        @(negedge clk);
        in_valid = v; in_data = 16'(x); c_tbl = tbl;
        c_r3 = 2'(e3); c_q3 = 16'(eq3); c_r9 = 4'(e9); c_q9 = 16'(eq9);
    endtask

    task automatic drive_calc(input bit v, input int x);
        drive(v, x, 1'b0, x % 3, x / 3, x % 9, x / 9);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R5)
        check(v3 == 1'b0, "R5 reset valid mod3", longint'(v3), 0);
        check(v9 == 1'b0, "R5 reset valid mod9", longint'(v9), 0);
        // port widths (R8)
        check($bits(r3) == 2, "R8 rem width mod3", $bits(r3), 2);
        check($bits(r9) == 4, "R8 rem width mod9", $bits(r9), 4);
        @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;

        // corner table streamed back to back (R6)
        for (int i = 0; i < NT; i++)
            drive(1'b1, TX[i], 1'b1, TR3[i], TQ3[i], TR9[i], TQ9[i]);

        // gapped pattern with junk data in bubbles (R9)
        for (int i = 0; i < 16; i++)
            drive_calc(i % 3 != 1, (i % 3 != 1) ? 40000 + 7 * i : 16'hBEEF);

        // reset while samples are in flight (R5)
        for (int i = 0; i < 3; i++) drive_calc(1'b1, 500 + i);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(v3 == 1'b0, "R5 flush mod3", longint'(v3), 0);
        check(v9 == 1'b0, "R5 flush mod9", longint'(v9), 0);
        rst = 1'b0;

        // exhaustive sweep, new value every cycle (R1, R2, R4, R7)
        for (int x = 0; x < 65536; x++) drive_calc(1'b1, x);
        // descending stream exercises stage alignment with large steps (R4)
        for (int x = 65535; x > 65535 - 64; x -= 5) drive_calc(1'b1, x);

        for (int i = 0; i < 8; i++) drive_calc(1'b0, 0);
        chk_on = 1'b0;
        summary();
        $finish;
    end
endmodule